// File: doc/BRIEF.md
# Shader Macro Expansion Sequencer

This block sits between instruction issue and the two arithmetic units of a pixel shader pipeline. It takes one shader operation at a time, together with its destination and up to three source register tags. Three macro operations are rewritten into short, fixed runs of primitive micro-ops: linear interpolation, power and vector normalize. Intermediate values go through a single scratch register whose tag is a parameter.

Every other operation leaves the block as one micro-op. A reduced-precision normalize is not expanded. It goes to a separate normalize side unit as one micro-op marked for that unit.

Both edges use a valid/ready handshake. The downstream ready may drop at any point in a sequence. The block then freezes on the current micro-op and refuses new work until the final micro-op of the sequence has been taken.

Top module: `shmx_top`

## Requirements
- R1: Opcode 8 (interpolate; a=w, b=a, c=b) yields two micro-ops. The first is MAD (code 2) with dst=T, a=w, b=b, c=b and neg=1. The second is MAD with dst=dst, a=w, b=a, c=T and neg=0. T is the scratch tag.
- R2: Opcode 9 (power; a=x, b=y) yields three micro-ops in this order:
  - LOG (code 3): dst=T, a=x.
  - MUL (code 1): dst=T, a=y, b=T.
  - EXP (code 4): dst=dst, a=T.
- R3: Opcode 10 (normalize; a=x) yields two micro-ops. The first is DP (code 5) with dst=T, a=x, b=x. The second is RSQ (code 6) with dst=dst, a=T, b=x and pair=1. The pair flag tells the second unit to scale b by the result in the same cycle.
- R4: Opcode 11 (reduced-precision normalize) yields one micro-op with code 7, dst=dst, a=x and side=1.
- R5: Any other opcode leaves unchanged as one micro-op with its own tags, all flags clear and last=1.
- R6: uop_last is 1 only on the final micro-op of a sequence.
- R7: in_ready is low from acceptance until the final micro-op is accepted. A new operation offered while in_ready is low is ignored. A new operation can be accepted in the same cycle as that final acceptance.
- R8: While uop_valid=1 and uop_ready=0, every micro-op output holds stable into the next cycle.
- R9: After reset, uop_valid=0 and in_ready=1.
- All fields that are not used in a micro-op read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| in_valid | input | 1 | operation offered |
| in_ready | output | 1 | operation can be taken |
| in_op | input | 4 | operation code |
| in_dst | input | TAG_W | destination tag |
| in_a | input | TAG_W | first source tag |
| in_b | input | TAG_W | second source tag |
| in_c | input | TAG_W | third source tag |
| uop_valid | output | 1 | micro-op present |
| uop_ready | input | 1 | downstream takes micro-op |
| uop_op | output | 4 | micro-op code |
| uop_dst | output | TAG_W | micro-op destination |
| uop_a | output | TAG_W | micro-op source a |
| uop_b | output | TAG_W | micro-op source b |
| uop_c | output | TAG_W | micro-op source c |
| uop_neg | output | 1 | negate source a |
| uop_pair | output | 1 | co-issued scale on second unit |
| uop_side | output | 1 | route to normalize side unit |
| uop_last | output | 1 | final micro-op of the operation |

## Verification
Two events can fall in the same cycle: the final micro-op of one sequence is handed downstream, and the next operation is accepted at the input. The bench provokes this by offering a pass-through operation while the last EXP of a power sequence is presented with uop_ready high. It then checks that in_ready is high in that cycle and that the new micro-op appears in the very next cycle. As a contrast, an interpolation offered during a stalled normalize must be refused, and the stalled DP must stay on the outputs.

// File: rtl/shmx_pkg.sv
package shmx_pkg;
    typedef logic [3:0] op_t;

    localparam op_t OP_MUL  = 4'd1;
    localparam op_t OP_MAD  = 4'd2;
    localparam op_t OP_LOG  = 4'd3;
    localparam op_t OP_EXP  = 4'd4;
    localparam op_t OP_DP   = 4'd5;
    localparam op_t OP_RSQ  = 4'd6;
    localparam op_t OP_NRMP = 4'd7;
    localparam op_t OP_LRP  = 4'd8;
    localparam op_t OP_POW  = 4'd9;
    localparam op_t OP_NRM  = 4'd10;
    localparam op_t OP_NRMH = 4'd11;

    // number of micro-ops an operation occupies
    function automatic logic [1:0] seq_len(op_t op);
        case (op)
            OP_POW:         return 2'd3;
            OP_LRP, OP_NRM: return 2'd2;
            default:        return 2'd1;
        endcase
    endfunction
endpackage

// File: rtl/shmx_ctrl.sv
module shmx_ctrl
    import shmx_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  op_t               in_op,
    input  logic [TAG_W-1:0]  in_dst,
    input  logic [TAG_W-1:0]  in_a,
    input  logic [TAG_W-1:0]  in_b,
    input  logic [TAG_W-1:0]  in_c,
    input  logic              uop_ready,
    input  logic              last,
    output logic              in_ready,
    output logic              busy,
    output logic [STEP_W-1:0] step,
    output op_t               cur_op,
    output logic [TAG_W-1:0]  cur_dst,
    output logic [TAG_W-1:0]  cur_a,
    output logic [TAG_W-1:0]  cur_b,
    output logic [TAG_W-1:0]  cur_c
);
    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
        op_t               op;
        logic [TAG_W-1:0]  dst;
        logic [TAG_W-1:0]  a;
        logic [TAG_W-1:0]  b;
        logic [TAG_W-1:0]  c;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        in_ready = !st_q.busy || (uop_ready && last);
        st_d     = st_q;
        if (in_valid && in_ready) begin
            st_d.busy = 1'b1;
            st_d.step = '0;
            st_d.op   = in_op;
            st_d.dst  = in_dst;
            st_d.a    = in_a;
            st_d.b    = in_b;
            st_d.c    = in_c;
        end else if (st_q.busy && uop_ready) begin
            if (last) st_d.busy = 1'b0;
            else      st_d.step = st_q.step + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign step    = st_q.step;
    assign cur_op  = st_q.op;
    assign cur_dst = st_q.dst;
    assign cur_a   = st_q.a;
    assign cur_b   = st_q.b;
    assign cur_c   = st_q.c;

    // R8: a refused micro-op keeps its step
    p_step_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !uop_ready) |=> (busy && $stable(step) && $stable(cur_op)));
endmodule

// File: rtl/shmx_expand.sv
module shmx_expand
    import shmx_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int STEP_W = 2,
    parameter logic [TAG_W-1:0] TMP_TAG = '1
) (
    input  op_t               op,
    input  logic [STEP_W-1:0] step,
    input  logic [TAG_W-1:0]  dst,
    input  logic [TAG_W-1:0]  a,
    input  logic [TAG_W-1:0]  b,
    input  logic [TAG_W-1:0]  c,
    output op_t               u_op,
    output logic [TAG_W-1:0]  u_dst,
    output logic [TAG_W-1:0]  u_a,
    output logic [TAG_W-1:0]  u_b,
    output logic [TAG_W-1:0]  u_c,
    output logic              u_neg,
    output logic              u_pair,
    output logic              u_side,
    output logic              u_last
);
    always_comb begin
        u_op   = op;
        u_dst  = dst;
        u_a    = a;
        u_b    = b;
        u_c    = c;
        u_neg  = 1'b0;
        u_pair = 1'b0;
        u_side = 1'b0;
        u_last = 1'b1;
        case (op)
            OP_LRP: begin
                u_op = OP_MAD;
                if (step == '0) begin
                    // T = -w*b + b
                    u_dst = TMP_TAG; u_b = c; u_neg = 1'b1; u_last = 1'b0;
                end else begin
                    // D = w*a + T
                    u_c = TMP_TAG;
                end
            end
            OP_POW: begin
                u_c = '0;
                if (step == '0) begin
                    u_op = OP_LOG; u_dst = TMP_TAG; u_b = '0; u_last = 1'b0;
                end else if (step == STEP_W'(1)) begin
                    u_op = OP_MUL; u_dst = TMP_TAG; u_a = b; u_b = TMP_TAG; u_last = 1'b0;
                end else begin
                    u_op = OP_EXP; u_a = TMP_TAG; u_b = '0;
                end
            end
            OP_NRM: begin
                u_c = '0;
                if (step == '0) begin
                    u_op = OP_DP; u_dst = TMP_TAG; u_b = a; u_last = 1'b0;
                end else begin
                    u_op = OP_RSQ; u_a = TMP_TAG; u_b = a; u_pair = 1'b1;
                end
            end
            OP_NRMH: begin
                u_op = OP_NRMP; u_b = '0; u_c = '0; u_side = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/shmx_top.sv
module shmx_top
    import shmx_pkg::*;
#(
    parameter int TAG_W = 5,
    parameter logic [TAG_W-1:0] TMP_TAG = 5'd30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [3:0]       in_op,
    input  logic [TAG_W-1:0] in_dst,
    input  logic [TAG_W-1:0] in_a,
    input  logic [TAG_W-1:0] in_b,
    input  logic [TAG_W-1:0] in_c,
    output logic             uop_valid,
    input  logic             uop_ready,
    output logic [3:0]       uop_op,
    output logic [TAG_W-1:0] uop_dst,
    output logic [TAG_W-1:0] uop_a,
    output logic [TAG_W-1:0] uop_b,
    output logic [TAG_W-1:0] uop_c,
    output logic             uop_neg,
    output logic             uop_pair,
    output logic             uop_side,
    output logic             uop_last
);
    localparam int STEP_W = 2;

    logic              busy;
    logic [STEP_W-1:0] step;
    op_t               cur_op;
    logic [TAG_W-1:0]  cur_dst, cur_a, cur_b, cur_c;

    shmx_ctrl #(.TAG_W(TAG_W), .STEP_W(STEP_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .uop_ready(uop_ready), .last(uop_last), .in_ready(in_ready),
        .busy(busy), .step(step), .cur_op(cur_op), .cur_dst(cur_dst),
        .cur_a(cur_a), .cur_b(cur_b), .cur_c(cur_c)
    );

    shmx_expand #(.TAG_W(TAG_W), .STEP_W(STEP_W), .TMP_TAG(TMP_TAG)) u_expand (
        .op(cur_op), .step(step), .dst(cur_dst), .a(cur_a), .b(cur_b), .c(cur_c),
        .u_op(uop_op), .u_dst(uop_dst), .u_a(uop_a), .u_b(uop_b), .u_c(uop_c),
        .u_neg(uop_neg), .u_pair(uop_pair), .u_side(uop_side), .u_last(uop_last)
    );

    assign uop_valid = busy;

    // checker: micro-ops handed out for the current operation
    logic [STEP_W-1:0] sent_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      sent_q <= '0;
        else if (uop_valid && uop_ready) sent_q <= uop_last ? '0 : sent_q + 1'b1;
    end

    // R6: last appears exactly at the sequence length
    p_last_at_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && uop_last) |-> (sent_q + 1'b1 == seq_len(cur_op)));
    // R7: input stays closed before the final micro-op
    p_ready_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_last) |-> !in_ready);
    // R8: outputs hold under backpressure
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_op) && $stable(uop_dst)
            && $stable(uop_a) && $stable(uop_b) && $stable(uop_c) && $stable(uop_last)));
    // R3: pairing only on the final reciprocal-root step
    p_pair_rsq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_pair) |-> (uop_last && uop_op == OP_RSQ));
    // R4: side-unit micro-op is a single one
    p_side_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_side) |-> (uop_last && uop_op == OP_NRMP && sent_q == '0));
endmodule

// File: tb/tb_shmx_top.sv
`timescale 1ns/1ps
module tb_shmx_top;
    localparam int TW = 5;
    localparam logic [TW-1:0] T = 5'd30;
    localparam int NV = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, uop_ready = 1'b0;
    logic [3:0] in_op = '0;
    logic [TW-1:0] in_dst = '0, in_a = '0, in_b = '0, in_c = '0;
    logic in_ready, uop_valid, uop_neg, uop_pair, uop_side, uop_last;
    logic [3:0] uop_op;
    logic [TW-1:0] uop_dst, uop_a, uop_b, uop_c;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    shmx_top dut (.*);

    // {stall at step 1, op, dst, a, b, c}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 4'd8,  5'd1, 5'd2,  5'd3,  5'd4},
        {1'b1, 4'd8,  5'd9, 5'd17, 5'd5,  5'd28},
        {1'b0, 4'd9,  5'd6, 5'd7,  5'd8,  5'd0},
        {1'b1, 4'd9,  5'd3, 5'd12, 5'd13, 5'd14},
        {1'b1, 4'd10, 5'd11, 5'd12, 5'd0, 5'd0},
        {1'b0, 4'd11, 5'd20, 5'd21, 5'd0, 5'd0},
        {1'b0, 4'd1,  5'd5, 5'd6,  5'd7,  5'd8},
        {1'b0, 4'd15, 5'd25, 5'd26, 5'd27, 5'd29}
    };

    function automatic int exp_len(logic [3:0] op);
        return (op == 4'd9) ? 3 : (op == 4'd8 || op == 4'd10) ? 2 : 1;
    endfunction

    // {op, dst, a, b, c, neg, pair, side, last}
    function automatic logic [27:0] exp_uop(logic [3:0] op, logic [TW-1:0] d, a, b, c, int k);
        case (op)
            4'd8:  return (k == 0) ? {4'd2, T, a, c, c, 4'b1000} : {4'd2, d, a, b, T, 4'b0001};
            4'd9:  return (k == 0) ? {4'd3, T, a, 5'd0, 5'd0, 4'b0000} :
                          (k == 1) ? {4'd1, T, b, T, 5'd0, 4'b0000} :
                                     {4'd4, d, T, 5'd0, 5'd0, 4'b0001};
            4'd10: return (k == 0) ? {4'd5, T, a, a, 5'd0, 4'b0000} : {4'd6, d, T, a, 5'd0, 4'b0101};
            4'd11: return {4'd7, d, a, 5'd0, 5'd0, 4'b0011};
            default: return {op, d, a, b, c, 4'b0001};
        endcase
    endfunction

    function automatic logic [27:0] got();
        return {uop_op, uop_dst, uop_a, uop_b, uop_c, uop_neg, uop_pair, uop_side, uop_last};
    endfunction

    task automatic chk(bit ok, string req, logic [27:0] act, logic [27:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic offer(logic [3:0] op, logic [TW-1:0] d, a, b, c);
        in_valid = 1'b1; in_op = op; in_dst = d; in_a = a; in_b = b; in_c = c;
    endtask

    task automatic run_vec(logic [24:0] v);
        logic [3:0] op = v[23:20];
        logic [TW-1:0] d = v[19:15], a = v[14:10], b = v[9:5], c = v[4:0];
        int n = exp_len(op);
        logic [27:0] e, held;
        @(negedge clk);
        offer(op, d, a, b, c); uop_ready = 1'b0;
        #1 chk(in_ready === 1'b1, "R7 idle ready", {27'd0, in_ready}, 28'd1);
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            uop_ready = 1'b0;
            #1;
            if (v[24] && k == 1) begin
                held = got();
                @(negedge clk);
                #1 chk(uop_valid && got() == held, "R8 stall hold", got(), held);
            end
            uop_ready = 1'b1;
            e = exp_uop(op, d, a, b, c, k);
            #1;
            chk(uop_valid && got() == e,
                op == 4'd8 ? "R1 lrp" : op == 4'd9 ? "R2 pow" : op == 4'd10 ? "R3 nrm" :
                op == 4'd11 ? "R4 side" : "R5 pass", got(), e);
            chk(uop_last == (k == n - 1), "R6 last flag", {27'd0, uop_last}, {27'd0, k == n - 1});
            chk(in_ready == (k == n - 1), "R7 ready window", {27'd0, in_ready}, {27'd0, k == n - 1});
        end
        @(negedge clk);
        uop_ready = 1'b0;
        #1 chk(!uop_valid, "R6 idle after last", {27'd0, uop_valid}, 28'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [27:0] e;
        #1 chk(!uop_valid && in_ready, "R9 reset", {26'd0, uop_valid, in_ready}, 28'd1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk(!uop_valid && in_ready, "R9 after reset", {26'd0, uop_valid, in_ready}, 28'd1);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R7: back-to-back acceptance on the final power micro-op
        @(negedge clk);
        offer(4'd9, 5'd2, 5'd4, 5'd6, 5'd0); uop_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        offer(4'd12, 5'd7, 5'd8, 5'd9, 5'd10);
        e = exp_uop(4'd9, 5'd2, 5'd4, 5'd6, 5'd0, 2);
        #1 chk(got() == e && in_ready, "R7 overlap ready", {got()[27:1], in_ready}, {e[27:1], 1'b1});
        @(negedge clk);
        in_valid = 1'b0; uop_ready = 1'b0;
        e = exp_uop(4'd12, 5'd7, 5'd8, 5'd9, 5'd10, 0);
        #1 chk(uop_valid && got() == e, "R5 R7 next op follows", got(), e);
        uop_ready = 1'b1;
        @(negedge clk);
        uop_ready = 1'b0;
        #1 chk(!uop_valid, "R6 idle", {27'd0, uop_valid}, 28'd0);

        // R7: an offer during a stalled normalize is ignored
        @(negedge clk);
        offer(4'd10, 5'd3, 5'd5, 5'd0, 5'd0);
        @(negedge clk);
        offer(4'd8, 5'd1, 5'd1, 5'd1, 5'd1);
        #1 chk(!in_ready, "R7 busy refuses", {27'd0, in_ready}, 28'd0);
        @(negedge clk);
        in_valid = 1'b0;
        e = exp_uop(4'd10, 5'd3, 5'd5, 5'd0, 5'd0, 0);
        #1 chk(uop_valid && got() == e, "R7 offer ignored", got(), e);
        uop_ready = 1'b1;
        @(negedge clk);
        e = exp_uop(4'd10, 5'd3, 5'd5, 5'd0, 5'd0, 1);
        #1 chk(uop_valid && got() == e, "R3 nrm after stall", got(), e);
        @(negedge clk);
        uop_ready = 1'b0;
        #1 chk(!uop_valid && in_ready, "R7 reopened", {26'd0, uop_valid, in_ready}, 28'd1);

        finish_run();
    end
endmodule